// File: doc/BRIEF.md
# Interrupt Status Register Group

This block holds the interrupt state of one function unit inside a larger device. Each of the 32 bit positions stands for one interrupt source. Hardware event inputs set and drop bits in a raw pending word, software enables sources through an enable word, and the AND of the two is the masked status. A single interrupt line is high while any masked bit is set. A one-cycle change pulse marks every transition of that line.

Software reaches four 32-bit registers through a simple register bus. A raw pending register can be read and written. A clear register is write-only: it drops every pending bit written as 1. An enable register can be read and written. A masked status register is read-only. A second access path, intended for debug and state save and restore, reads and writes the pending and enable storage directly. It has none of the bus path's side effects. Register offsets are parameters. Both read ports are registered and return data one cycle after the address is presented.

Top module: `irq_regblock`

## Requirements
- R1: A bus write to the pending offset (default 0x00) replaces the whole pending word, and a bus read of that offset returns it.
- R2: The enable offset (default 0x08) reads back what was written. The status offset (default 0x0C) reads as pending AND enable. The clear offset (default 0x04) always reads as zero.
- R3: A bus write to the clear offset drops, in the pending word, each bit that is 1 in the written data and leaves every other bit unchanged.
- R4: Each 1 bit of `hw_raise` sets that pending bit and each 1 bit of `hw_lower` drops it. When a raise lands on the same bit as a bus clear, a lower or a pending write in the same cycle, the raise wins and the bit ends up set.
- R5: `irq_out` is 1 exactly when pending AND enable is non-zero. It follows the register state that results from each clock edge.
- R6: `irq_chg` is high for exactly one cycle, in the cycle after the edge at which `irq_out` changed level. It stays low when an update leaves the level of `irq_out` unchanged.
- R7: The debug port writes the pending and enable words directly at their offsets and reads them back. At the clear and status offsets it reads zero, and a write there has no effect. A debug write to pending or enable never causes `irq_chg`, even when `irq_out` changes as a result.
- R8: While `rst` is high, the pending word, the enable word, `irq_out`, `irq_chg` and both read ports are forced to zero.
- R9: A bus write to the status offset or to an unmapped offset changes nothing, and a read of an unmapped offset returns zero.
- R10: `bus_rdata` and `dbg_rdata` present the register value one clock edge after the address. A write in the same cycle is seen only by later reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register bus byte offset |
| bus_we | input | 1 | Register bus write enable |
| bus_wdata | input | DATA_W | Register bus write data |
| bus_rdata | output | DATA_W | Register bus read data, registered |
| dbg_addr | input | ADDR_W | Debug port byte offset |
| dbg_we | input | 1 | Debug port write enable |
| dbg_wdata | input | DATA_W | Debug port write data |
| dbg_rdata | output | DATA_W | Debug port read data, registered |
| hw_raise | input | DATA_W | Per-source set events |
| hw_lower | input | DATA_W | Per-source drop events |
| irq_out | output | 1 | Interrupt line, high while masked status is non-zero |
| irq_chg | output | 1 | One-cycle pulse on each change of irq_out |

## Verification
A hardware raise and a software clear of the same pending bit can arrive at the same clock edge. The bench provokes this by driving `hw_raise` in the cycle of a bus write to the clear offset, and again together with `hw_lower`. It then reads the pending word back and expects the bit still set. The second collision is a debug write that flips `irq_out`. There the bench expects the new level with `irq_chg` held low, and a hardware-driven change a few cycles later must still give its pulse.

// File: rtl/irq_regblock_pkg.sv
package irq_regblock_pkg;

  typedef enum logic [2:0] {
    SEL_NONE = 3'd0,
    SEL_PEND = 3'd1,
    SEL_CLR  = 3'd2,
    SEL_EN   = 3'd3,
    SEL_STAT = 3'd4
  } reg_sel_e;

endpackage

// File: rtl/irq_addr_dec.sv
module irq_addr_dec
  import irq_regblock_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int OFS_PEND = 'h00,
  parameter int OFS_CLR  = 'h04,
  parameter int OFS_EN   = 'h08,
  parameter int OFS_STAT = 'h0C
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);

  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(OFS_PEND);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFS_CLR);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(OFS_EN);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);

  always_comb begin
    sel = SEL_NONE;
    if (addr == A_PEND)      sel = SEL_PEND;
    else if (addr == A_CLR)  sel = SEL_CLR;
    else if (addr == A_EN)   sel = SEL_EN;
    else if (addr == A_STAT) sel = SEL_STAT;
  end

endmodule

// File: rtl/irq_bit_slice.sv
module irq_bit_slice (
  input  logic clk,
  input  logic rst,
  input  logic pend_wr_bus,
  input  logic pend_wr_dbg,
  input  logic clr_wr_bus,
  input  logic en_wr_bus,
  input  logic en_wr_dbg,
  input  logic wd_bus,
  input  logic wd_dbg,
  input  logic raise,
  input  logic lower,
  output logic pend_q,
  output logic en_q,
  output logic pend_d,
  output logic en_d
);

  // pending bit: direct writes first, then drops, then a raise overrides all
  always_comb begin
    pend_d = pend_q;
    if (pend_wr_dbg)      pend_d = wd_dbg;
    else if (pend_wr_bus) pend_d = wd_bus;
    if (clr_wr_bus && wd_bus) pend_d = 1'b0;
    if (lower)                pend_d = 1'b0;
    if (raise)                pend_d = 1'b1;
  end

  always_comb begin
    en_d = en_q;
    if (en_wr_dbg)      en_d = wd_dbg;
    else if (en_wr_bus) en_d = wd_bus;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      pend_q <= pend_d;
      en_q   <= en_d;
    end
  end

endmodule

// File: rtl/irq_line_out.sv
module irq_line_out #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] pend_d,
  input  logic [DATA_W-1:0] en_d,
  input  logic              quiet,
  output logic              irq_q,
  output logic              chg_q
);

  logic lvl_d;

  assign lvl_d = |(pend_d & en_d);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
      chg_q <= 1'b0;
    end else begin
      irq_q <= lvl_d;
      chg_q <= (lvl_d != irq_q) && !quiet;
    end
  end

endmodule

// File: rtl/irq_regblock.sv
module irq_regblock
  import irq_regblock_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 8,
  parameter int OFS_PEND = 'h00,
  parameter int OFS_CLR  = 'h04,
  parameter int OFS_EN   = 'h08,
  parameter int OFS_STAT = 'h0C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [ADDR_W-1:0] dbg_addr,
  input  logic              dbg_we,
  input  logic [DATA_W-1:0] dbg_wdata,
  output logic [DATA_W-1:0] dbg_rdata,
  input  logic [DATA_W-1:0] hw_raise,
  input  logic [DATA_W-1:0] hw_lower,
  output logic              irq_out,
  output logic              irq_chg
);

  reg_sel_e bus_sel;
  reg_sel_e dbg_sel;

  logic [DATA_W-1:0] pend_q, en_q, pend_d, en_d;
  logic pend_wr_bus, clr_wr_bus, en_wr_bus;
  logic pend_wr_dbg, en_wr_dbg;

  irq_addr_dec #(
    .ADDR_W(ADDR_W), .OFS_PEND(OFS_PEND), .OFS_CLR(OFS_CLR),
    .OFS_EN(OFS_EN), .OFS_STAT(OFS_STAT)
  ) i_bus_dec (
    .addr(bus_addr),
    .sel (bus_sel)
  );

  irq_addr_dec #(
    .ADDR_W(ADDR_W), .OFS_PEND(OFS_PEND), .OFS_CLR(OFS_CLR),
    .OFS_EN(OFS_EN), .OFS_STAT(OFS_STAT)
  ) i_dbg_dec (
    .addr(dbg_addr),
    .sel (dbg_sel)
  );

  assign pend_wr_bus = bus_we && (bus_sel == SEL_PEND);
  assign clr_wr_bus  = bus_we && (bus_sel == SEL_CLR);
  assign en_wr_bus   = bus_we && (bus_sel == SEL_EN);
  assign pend_wr_dbg = dbg_we && (dbg_sel == SEL_PEND);
  assign en_wr_dbg   = dbg_we && (dbg_sel == SEL_EN);

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    irq_bit_slice i_slice (
      .clk        (clk),
      .rst        (rst),
      .pend_wr_bus(pend_wr_bus),
      .pend_wr_dbg(pend_wr_dbg),
      .clr_wr_bus (clr_wr_bus),
      .en_wr_bus  (en_wr_bus),
      .en_wr_dbg  (en_wr_dbg),
      .wd_bus     (bus_wdata[b]),
      .wd_dbg     (dbg_wdata[b]),
      .raise      (hw_raise[b]),
      .lower      (hw_lower[b]),
      .pend_q     (pend_q[b]),
      .en_q       (en_q[b]),
      .pend_d     (pend_d[b]),
      .en_d       (en_d[b])
    );
  end

  irq_line_out #(.DATA_W(DATA_W)) i_line (
    .clk   (clk),
    .rst   (rst),
    .pend_d(pend_d),
    .en_d  (en_d),
    .quiet (pend_wr_dbg || en_wr_dbg),
    .irq_q (irq_out),
    .chg_q (irq_chg)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      unique case (bus_sel)
        SEL_PEND: bus_rdata <= pend_q;
        SEL_EN:   bus_rdata <= en_q;
        SEL_STAT: bus_rdata <= pend_q & en_q;
        default:  bus_rdata <= '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dbg_rdata <= '0;
    end else begin
      unique case (dbg_sel)
        SEL_PEND: dbg_rdata <= pend_q;
        SEL_EN:   dbg_rdata <= en_q;
        default:  dbg_rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/irq_regblock_chk.sv
module irq_regblock_chk #(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 8,
  parameter int OFS_PEND = 'h00,
  parameter int OFS_EN   = 'h08
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] dbg_addr,
  input logic              dbg_we,
  input logic [DATA_W-1:0] hw_raise,
  input logic [DATA_W-1:0] pend_q,
  input logic [DATA_W-1:0] en_q,
  input logic              irq_out,
  input logic              irq_chg
);

  logic dbg_hit;
  assign dbg_hit = dbg_we && ((dbg_addr == ADDR_W'(OFS_PEND)) || (dbg_addr == ADDR_W'(OFS_EN)));

  // R4: raised bits are set after the edge regardless of other writes
  a_r4_raise_wins: assert property (@(posedge clk) disable iff (rst)
    (|hw_raise) |=> ((pend_q & $past(hw_raise)) == $past(hw_raise)));

  // R5: line level tracks masked status
  a_r5_line_level: assert property (@(posedge clk) disable iff (rst)
    irq_out == (|(pend_q & en_q)));

  // R6: a pulse only follows a real level change
  a_r6_pulse_on_change: assert property (@(posedge clk) disable iff (rst)
    irq_chg |-> (irq_out != $past(irq_out)));

  // R6: never two pulses back to back without a level change between
  a_r6_single_cycle: assert property (@(posedge clk) disable iff (rst)
    irq_chg |=> (!irq_chg || (irq_out != $past(irq_out))));

  // R7: debug writes to storage never pulse
  a_r7_dbg_quiet: assert property (@(posedge clk) disable iff (rst)
    dbg_hit |=> !irq_chg);

  // R8: reset clears the state
  a_r8_reset_zero: assert property (@(posedge clk)
    rst |=> (pend_q == '0 && en_q == '0 && !irq_out && !irq_chg));

endmodule

bind irq_regblock irq_regblock_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .OFS_PEND(OFS_PEND), .OFS_EN(OFS_EN)
) i_irq_regblock_chk (
  .clk     (clk),
  .rst     (rst),
  .dbg_addr(dbg_addr),
  .dbg_we  (dbg_we),
  .hw_raise(hw_raise),
  .pend_q  (pend_q),
  .en_q    (en_q),
  .irq_out (irq_out),
  .irq_chg (irq_chg)
);

// File: tb/test_irq_regblock.sv
module test_irq_regblock;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int AW = 8;
  localparam logic [AW-1:0] O_PEND = 8'h00;
  localparam logic [AW-1:0] O_CLR  = 8'h04;
  localparam logic [AW-1:0] O_EN   = 8'h08;
  localparam logic [AW-1:0] O_STAT = 8'h0C;
  localparam logic [AW-1:0] O_NONE = 8'h10;

  typedef struct packed {
    logic          rd;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    logic          irq;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b0, O_PEND, 32'h0000_00F0, 1'b0},  // R1
    '{1'b1, O_PEND, 32'h0000_00F0, 1'b0},  // R1
    '{1'b0, O_EN,   32'h0000_0030, 1'b1},  // R2 R5
    '{1'b1, O_EN,   32'h0000_0030, 1'b1},  // R2
    '{1'b1, O_STAT, 32'h0000_0030, 1'b1},  // R2
    '{1'b1, O_CLR,  32'h0000_0000, 1'b1},  // R2
    '{1'b0, O_CLR,  32'h0000_0010, 1'b1},  // R3
    '{1'b1, O_PEND, 32'h0000_00E0, 1'b1},  // R3
    '{1'b1, O_STAT, 32'h0000_0020, 1'b1},  // R3
    '{1'b0, O_STAT, 32'h0000_FFFF, 1'b1},  // R9
    '{1'b1, O_STAT, 32'h0000_0020, 1'b1},  // R9
    '{1'b0, O_NONE, 32'h0000_00FF, 1'b1},  // R9
    '{1'b1, O_NONE, 32'h0000_0000, 1'b1},  // R9
    '{1'b1, O_PEND, 32'h0000_00E0, 1'b1},  // R9
    '{1'b0, O_EN,   32'h0000_0000, 1'b0},  // R5
    '{1'b1, O_STAT, 32'h0000_0000, 1'b0}   // R5
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic [AW-1:0] dbg_addr = '0;
  logic          dbg_we = 1'b0;
  logic [DW-1:0] dbg_wdata = '0;
  logic [DW-1:0] dbg_rdata;
  logic [DW-1:0] hw_raise = '0;
  logic [DW-1:0] hw_lower = '0;
  logic          irq_out;
  logic          irq_chg;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_regblock i_irq_regblock (
    .clk(clk), .rst(rst),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dbg_addr(dbg_addr), .dbg_we(dbg_we), .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata),
    .hw_raise(hw_raise), .hw_lower(hw_lower),
    .irq_out(irq_out), .irq_chg(irq_chg)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic dbg_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    dbg_addr = a; dbg_wdata = d; dbg_we = 1'b1;
    @(negedge clk);
    dbg_we = 1'b0;
  endtask

  task automatic dbg_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
    dbg_addr = a; dbg_we = 1'b0;
    @(negedge clk);
    d = dbg_rdata;
  endtask

  task automatic pulse_hw(input logic [DW-1:0] r, input logic [DW-1:0] l);
    hw_raise = r; hw_lower = l;
    @(negedge clk);
    hw_raise = '0; hw_lower = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] rv;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R8: reset state
    check("R8 irq_out after reset", DW'(irq_out), 0);
    check("R8 irq_chg after reset", DW'(irq_chg), 0);
    bus_read(O_PEND, rv);
    check("R8 pending after reset", rv, 0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].rd) begin
        bus_read(VECS[i].addr, rv);
        check($sformatf("R1/R2/R3/R9 vec %0d read", i), rv, VECS[i].data);
      end else begin
        bus_write(VECS[i].addr, VECS[i].data);
      end
      check($sformatf("R5 vec %0d irq_out", i), DW'(irq_out), DW'(VECS[i].irq));
    end

    // R10: read issued in the write cycle returns old value
    bus_addr = O_PEND; bus_wdata = 32'h0000_0001; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    check("R10 same-cycle read old", bus_rdata, 32'h0000_00E0);
    @(negedge clk);
    check("R10 next read new", bus_rdata, 32'h0000_0001);

    // R6: level changes and pulses
    bus_write(O_PEND, 32'h0);
    bus_write(O_EN, 32'h0000_0001);
    pulse_hw(32'h1, 32'h0);
    check("R6 irq_out rises", DW'(irq_out), 1);
    check("R6 pulse on rise", DW'(irq_chg), 1);
    @(negedge clk);
    check("R6 pulse one cycle", DW'(irq_chg), 0);
    pulse_hw(32'h4, 32'h0);
    check("R6 no pulse masked raise", DW'(irq_chg), 0);
    pulse_hw(32'h1, 32'h0);
    check("R6 no pulse re-raise", DW'(irq_chg), 0);

    // R4: raise wins against clear and lower in the same cycle
    bus_addr = O_CLR; bus_wdata = 32'h0000_0005; bus_we = 1'b1;
    hw_raise = 32'h1;
    @(negedge clk);
    bus_we = 1'b0; hw_raise = '0;
    check("R4 raise beats clear irq", DW'(irq_out), 1);
    bus_read(O_PEND, rv);
    check("R4 raise beats clear pend", rv, 32'h0000_0001);
    pulse_hw(32'h2, 32'h2);
    bus_read(O_PEND, rv);
    check("R4 raise beats lower", rv, 32'h0000_0003);
    pulse_hw(32'h0, 32'h3);
    check("R4 lower drops irq", DW'(irq_out), 0);
    check("R6 pulse on fall", DW'(irq_chg), 1);
    bus_read(O_PEND, rv);
    check("R4 lower clears pend", rv, 32'h0);

    // R7: debug path
    dbg_write(O_PEND, 32'h0000_0001);
    check("R7 dbg write sets irq", DW'(irq_out), 1);
    check("R7 dbg write no pulse", DW'(irq_chg), 0);
    dbg_read(O_PEND, rv);
    check("R7 dbg read pend", rv, 32'h0000_0001);
    dbg_read(O_EN, rv);
    check("R7 dbg read en", rv, 32'h0000_0001);
    dbg_read(O_STAT, rv);
    check("R7 dbg read status zero", rv, 32'h0);
    dbg_write(O_CLR, 32'h0000_0001);
    bus_read(O_PEND, rv);
    check("R7 dbg clr offset no effect", rv, 32'h0000_0001);
    dbg_write(O_EN, 32'h0);
    check("R7 dbg mask off irq", DW'(irq_out), 0);
    check("R7 dbg mask off no pulse", DW'(irq_chg), 0);
    bus_write(O_EN, 32'h0000_0001);
    check("R6 bus enable pulses", DW'(irq_chg), 1);

    // R8: reset mid-run
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R8 irq_out cleared", DW'(irq_out), 0);
    bus_read(O_EN, rv);
    check("R8 enable cleared", rv, 32'h0);
    bus_read(O_PEND, rv);
    check("R8 pending cleared", rv, 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule